// File: doc/BRIEF.md
# Automatic Baud Rate Detector

This block finds the bit rate of an asynchronous serial link by timing a known training byte. The training byte is 0x55. With its start bit (0) and stop bit (1), and its data bits sent least significant bit first, it puts ten levels on the wire that alternate between low and high, each one bit time wide. The line rests high between frames. Software or a controller pulses `arm_i`. The detector then waits for the falling edge of the start bit. It times the nine segments that lie between that edge and the ninth edge after it, and reports a divisor that a 16x oversampling receiver can load for its baud tick.

The divisor is the measured bit period over 16, rounded to the nearest integer, and it is computed without a hardware divider. The block also checks each timed segment against the average of all nine. It rejects the measurement if one segment is too far off, or if no edge arrives within a parameterised limit. A rate error of about 2% is the most a link tolerates, so a detector that refuses a distorted training byte is safer than one that reports a poor divisor.

Top module: `autobaud_detector`

## Requirements
- R1: After reset `done_o`, `err_o` and `busy_o` are low, `divisor_o` is zero and `rx_i` is treated as idle high.
- R2: A one-cycle pulse on `arm_i` raises `busy_o` and clears `done_o` and `err_o` in the next cycle. While armed, only a falling edge of `rx_i` starts timing. A line that is low at arm time and then rises does not start it.
- R3: Let T be the sum, in clock cycles, of the nine segments from the start falling edge to the ninth later edge. The divisor is floor((T+72)/144). For equal segments of P cycles this equals floor((P+8)/16).
- R4: A good measurement ends with `done_o` high and `busy_o` low. `done_o` and `divisor_o` hold until the next arm. `done_o` and `err_o` are never high together.
- R5: If any segment S satisfies 8*|9*S - T| > T, meaning it differs from the average by more than one eighth of a bit, the run ends with `err_o` high and `done_o` low.
- R6: A segment longer than `TIMEOUT_CYC` cycles aborts the run with `err_o`. An edge that closes a segment of exactly `TIMEOUT_CYC` cycles arrives in the same cycle as the timeout would fire, and the edge wins.
- R7: Activity on `rx_i` while the block is not armed leaves `done_o`, `err_o` and `divisor_o` unchanged.
- R8: An `arm_i` pulse during a measurement drops the partial run and waits for a fresh start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start or restart a detection |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| busy_o | output | 1 | Armed, timing or computing |
| done_o | output | 1 | Divisor valid |
| err_o | output | 1 | Inconsistent segments or timeout |
| divisor_o | output | $clog2(TIMEOUT_CYC/16+2) | Bit period over 16, rounded |

## Verification
The edge that closes a segment and the timeout of that segment can fall in the same cycle. The bench provokes this with training bytes whose bit period equals the timeout limit (512 cycles) and exceeds it by one cycle. The first must complete with divisor 32, and the second must end in `err_o`. A second collision is an arm pulse while a segment is still being timed. It is judged by the divisor of the frame that follows, which must reflect only that frame.

// File: rtl/abd_pkg.sv
package abd_pkg;
  localparam int unsigned NSEG    = 9;    // segments timed per training byte
  localparam int unsigned RND_ADD = 72;   // half of DEN, for rounding
  localparam int unsigned DEN     = 144;  // NSEG * 16
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_MEAS, ST_CHECK, ST_DIV
  } abd_state_e;
endpackage

// File: rtl/abd_edge_sync.sv
module abd_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o,
  output logic edge_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      prev_q <= sync_q[1];
    end
  end

  assign fall_o = prev_q & ~sync_q[1];
  assign edge_o = prev_q ^ sync_q[1];
endmodule

// File: rtl/abd_seg_meter.sv
module abd_seg_meter
  import abd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 4096,
  parameter int unsigned CNT_W = 13,
  parameter int unsigned TOT_W = 17
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       run_i,
  input  logic                       edge_i,
  output logic [NSEG-1:0][CNT_W-1:0] segs_o,
  output logic [TOT_W-1:0]           total_o,
  output logic                       last_o,
  output logic                       tmo_o
);
  localparam int unsigned IDX_W = $clog2(NSEG);

  logic [CNT_W-1:0] cnt_q, seg_len;
  logic [TOT_W-1:0] total_q;
  logic [IDX_W-1:0] idx_q;
  logic             cap;

  assign cap     = run_i & edge_i;
  assign seg_len = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      total_q <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      cnt_q   <= '0;
      total_q <= '0;
      idx_q   <= '0;
    end else if (cap) begin
      cnt_q   <= '0;
      total_q <= total_q + TOT_W'(seg_len);
      idx_q   <= idx_q + IDX_W'(1);
    end else if (run_i) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            segs_o[i] <= '0;
      else if (cap && idx_q == IDX_W'(i))     segs_o[i] <= seg_len;
    end
  end

  assign total_o = total_q;
  assign last_o  = cap && (idx_q == IDX_W'(NSEG-1));
  assign tmo_o   = run_i && !edge_i && (cnt_q == CNT_W'(TIMEOUT_CYC-1));

  // timer never runs past the limit while timing
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < CNT_W'(TIMEOUT_CYC)));
endmodule

// File: rtl/abd_consist.sv
module abd_consist
  import abd_pkg::*;
#(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned TOT_W = 17
) (
  input  logic [NSEG-1:0][CNT_W-1:0] segs_i,
  input  logic [TOT_W-1:0]           total_i,
  output logic                       bad_o
);
  localparam int unsigned W = TOT_W + 4;
  logic [NSEG-1:0] over;

  for (genvar i = 0; i < NSEG; i++) begin : g_chk
    logic [W-1:0] nine_s, tot_w, diff;
    assign nine_s  = (W'(segs_i[i]) << 3) + W'(segs_i[i]);
    assign tot_w   = W'(total_i);
    assign diff    = (nine_s > tot_w) ? nine_s - tot_w : tot_w - nine_s;
    assign over[i] = (diff << 3) > tot_w;
  end

  assign bad_o = |over;
endmodule

// File: rtl/abd_div144.sv
module abd_div144
  import abd_pkg::*;
#(
  parameter int unsigned TOT_W = 17,
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TOT_W-1:0] total_i,
  output logic             valid_o,
  output logic [DIV_W-1:0] quot_o
);
  logic [TOT_W:0] rem_q;
  logic           run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      run_q   <= 1'b0;
      quot_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        rem_q  <= (TOT_W+1)'(total_i) + (TOT_W+1)'(RND_ADD);
        quot_o <= '0;
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (rem_q >= (TOT_W+1)'(DEN)) begin
          rem_q  <= rem_q - (TOT_W+1)'(DEN);
          quot_o <= quot_o + DIV_W'(1);
        end else begin
          run_q   <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assert_rem_final_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rem_q < (TOT_W+1)'(DEN)));
endmodule

// File: rtl/autobaud_detector.sv
module autobaud_detector
  import abd_pkg::*;
#(
  parameter  int unsigned TIMEOUT_CYC = 4096,
  localparam int unsigned DIV_W = $clog2(TIMEOUT_CYC/16 + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             rx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [DIV_W-1:0] divisor_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned TOT_W = CNT_W + 4;

  abd_state_e                 state_q;
  logic                       fall, edge_any;
  logic [NSEG-1:0][CNT_W-1:0] segs;
  logic [TOT_W-1:0]           total;
  logic                       last, tmo, bad, div_valid;
  logic [DIV_W-1:0]           quot;
  logic                       meas_start, div_start;

  assign meas_start = (state_q == ST_WAIT) && fall && !arm_i;
  assign div_start  = (state_q == ST_CHECK) && !bad && !arm_i;

  abd_edge_sync i_sync (
    .clk_i, .rst_ni, .rx_i, .fall_o(fall), .edge_o(edge_any)
  );

  abd_seg_meter #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W), .TOT_W(TOT_W)) i_meter (
    .clk_i, .rst_ni,
    .start_i(meas_start),
    .run_i  (state_q == ST_MEAS && !arm_i),
    .edge_i (edge_any),
    .segs_o (segs),
    .total_o(total),
    .last_o (last),
    .tmo_o  (tmo)
  );

  abd_consist #(.CNT_W(CNT_W), .TOT_W(TOT_W)) i_consist (
    .segs_i(segs), .total_i(total), .bad_o(bad)
  );

  abd_div144 #(.TOT_W(TOT_W), .DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni, .start_i(div_start), .total_i(total),
    .valid_o(div_valid), .quot_o(quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      divisor_o <= '0;
    end else if (arm_i) begin
      state_q <= ST_WAIT;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT:  if (fall) state_q <= ST_MEAS;
        ST_MEAS: begin
          if (last)     state_q <= ST_CHECK;
          else if (tmo) begin
            state_q <= ST_IDLE;
            err_o   <= 1'b1;
          end
        end
        ST_CHECK: begin
          if (bad) begin
            state_q <= ST_IDLE;
            err_o   <= 1'b1;
          end else state_q <= ST_DIV;
        end
        ST_DIV: if (div_valid) begin
          state_q   <= ST_IDLE;
          done_o    <= 1'b1;
          divisor_o <= quot;
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_arm_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (busy_o && !done_o && !err_o));
  assert_flags_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o) && !(busy_o && (done_o || err_o)));
  assert_result_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> (done_o && $stable(divisor_o)));
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !arm_i) |=> ($stable(done_o) && $stable(err_o) && $stable(divisor_o)));
endmodule

// File: tb/test_autobaud_detector.sv
`timescale 1ns/1ps
module test_autobaud_detector;
  localparam int TO    = 512;
  localparam int DIV_W = $clog2(TO/16 + 2);

  typedef struct packed { int per; int k; int d; } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{160, 0, 0}, '{168, 0, 0}, '{167, 0, 0}, '{40, 0, 0}, '{512, 0, 0},
    '{160, 3, 22}, '{160, 5, 23}, '{513, 0, 0}, '{160, 8, -22}, '{24, 0, 0}
  };

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, rx = 1'b1;
  logic busy, done, err;
  logic [DIV_W-1:0] divisor;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  autobaud_detector #(.TIMEOUT_CYC(TO)) i_autobaud_detector (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .rx_i(rx),
    .busy_o(busy), .done_o(done), .err_o(err), .divisor_o(divisor)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arm();
    arm = 1'b1; tick(1); arm = 1'b0;
  endtask

  task automatic send_frame(input int p, input int k, input int d);
    for (int i = 0; i < 9; i++) begin
      rx = i[0];
      tick(p + ((i == k) ? d : 0));
    end
    rx = 1'b1;
    tick(p);
  endtask

  task automatic wait_result();
    for (int i = 0; i < 20000; i++) begin
      if (done || err) break;
      tick(1);
    end
  endtask

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit exp_err(input vec_t v);
    int t = 9*v.per + v.d;
    if (v.per > TO || v.per + v.d > TO) return 1;
    if (8*absi(9*v.per - t) > t) return 1;
    if (8*absi(9*(v.per + v.d) - t) > t) return 1;
    return 0;
  endfunction

  function automatic int exp_div(input vec_t v);
    return (9*v.per + v.d + 72) / 144;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int last_div;
    tick(3);
    // R1 reset state
    chk(!done && !err && !busy && divisor == 0, "R1", {busy, done, err}, 0);
    rst_n = 1'b1;
    tick(3);
    chk(!busy && divisor == 0, "R1", busy, 0);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      pulse_arm();
      // R2 arm raises busy and clears flags
      chk(busy && !done && !err, "R2", {busy, done, err}, 4);
      tick(4);
      send_frame(v.per, v.k, v.d);
      wait_result();
      tick(2);
      if (exp_err(v)) begin
        // R5 / R6 rejection
        chk(err && !done && !busy, (v.per > TO) ? "R6" : "R5", {done, err}, 1);
      end else begin
        // R3 divisor, R4 done; vector 4 is the R6 edge-wins-timeout case
        chk(done && !err && !busy, (i == 4) ? "R6" : "R4", {done, err}, 2);
        chk(divisor == exp_div(v), "R3", divisor, exp_div(v));
      end
    end

    // R7: frame without arm leaves result alone
    pulse_arm(); tick(4);
    send_frame(200, 0, 0); wait_result(); tick(2);
    last_div = divisor;
    chk(done && divisor == 13, "R3", divisor, 13);
    send_frame(80, 0, 0); tick(40);
    chk(done && !err && divisor == last_div, "R7", divisor, last_div);

    // R2: armed with line low, a rising edge must not start timing
    rx = 1'b0; tick(10);
    pulse_arm(); tick(4);
    rx = 1'b1; tick(300);
    chk(busy && !done && !err, "R2", {busy, done, err}, 4);
    send_frame(96, 0, 0); wait_result(); tick(2);
    chk(done && divisor == 6, "R2", divisor, 6);

    // R8: re-arm mid-measurement, only the new frame counts
    pulse_arm(); tick(4);
    rx = 1'b0; tick(100); rx = 1'b1; tick(100); rx = 1'b0; tick(50);
    pulse_arm();
    rx = 1'b1; tick(300);
    chk(busy && !done && !err, "R8", {busy, done, err}, 4);
    send_frame(248, 0, 0); wait_result(); tick(2);
    chk(done && divisor == 16, "R8", divisor, 16);

    // R6: line stuck low after start
    pulse_arm(); tick(4);
    rx = 1'b0; tick(TO + 20);
    chk(err && !done && !busy, "R6", {done, err}, 1);
    rx = 1'b1; tick(10);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule